// File: doc/BRIEF.md
# Mesochronous Half-Full Elastic Buffer

This block carries a word stream between two clock domains that share one frequency but sit at an unknown, fixed phase offset from each other. A typical case is two branches of one clock that reach their logic through different insertion delays. The block is a small ring of storage. The write pointer and the read pointer each advance freely in their own domain. The write pointer crosses to the read side in Gray code through a two-stage synchronizer.

After reset, the read side stays in a priming phase. In that phase it holds its read pointer at zero and drives nothing valid. It leaves priming once its synchronized view of the write count reaches half the depth. From then on, both sides move one word per clock with no flow control in either direction. The transmitter must present a new word on every cycle in which `tx_ready` is high, because there is no valid strobe and no back-pressure. The receiver must accept a word on every cycle in which `rx_valid` is high, because it has no ready input. Matched frequencies keep the fill level near its midpoint. If the fill level drifts to empty or full, a sticky error flag is set.

Top module: `meso_elastic_buf`

## Requirements
- R1: While either reset is low, `tx_ready`, `rx_valid` and `drift_err` are 0.
- R2: `tx_ready` rises a few `tx_clk` cycles after both resets are high and then stays high until the next reset. On every rising `tx_clk` edge at which `tx_ready` is 1, the word on `tx_data` is stored.
- R3: During priming the read pointer stays at 0. Priming ends on the first `rx_clk` edge at which the synchronized write count is at least DEPTH/2. The first `rx_valid` therefore follows the rise of `tx_ready` by no less than DEPTH/2 and no more than DEPTH/2+6 clock periods.
- R4: `rx_valid` is 0 throughout priming. Once it rises, it stays 1 on every `rx_clk` cycle until a reset, with one new word per cycle.
- R5: For any fixed phase offset, the words on `rx_data` while `rx_valid` is 1 are exactly the stored words, in storage order, with none lost or repeated.
- R6: After priming, `drift_err` becomes 1 if the synchronized fill level (written count minus read count, modulo twice the depth) equals 0 or is at least DEPTH. It then stays 1 until a reset.
- R7: With both clocks running unbroken at the same frequency, `drift_err` stays 0. The number of words stored but not yet delivered never exceeds DEPTH.
- R8: A reset on either side alone restarts both sides: writing restarts at the first slot, priming is repeated, and `drift_err` is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Transmit-side clock |
| tx_rst_n | input | 1 | Transmit-side reset, active low |
| tx_data | input | DATA_W | Word stored on each `tx_clk` edge while `tx_ready` is 1 |
| tx_ready | output | 1 | Write side is live; a word is taken on every cycle |
| rx_clk | input | 1 | Receive-side clock, same frequency as `tx_clk` |
| rx_rst_n | input | 1 | Receive-side reset, active low |
| rx_data | output | DATA_W | Delivered word |
| rx_valid | output | 1 | `rx_data` holds a new word this cycle |
| drift_err | output | 1 | Sticky flag: fill level left its safe window |

## Verification
The stream is checked with three word patterns: a counting sequence, a scrambled sequence and an alternating bit pattern. Each runs at a different receive-clock phase offset. The counting sequence shows a lost or repeated word as a step of the wrong size. The scrambled sequence exposes reads from the wrong slot. The alternating pattern exposes stuck or swapped data bits. Drift is forced in both directions by stalling one clock: a stall on the receive side overfills the buffer, and a stall on the transmit side drains it. Each stall is followed by a reset on one side only, to show that the error flag is sticky and that the other side also restarts.

// File: rtl/meso_pkg.sv
`timescale 1ns/1ps
package meso_pkg;

  typedef enum logic {
    RD_PRIME = 1'b0,
    RD_FLOW  = 1'b1
  } rd_state_e;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/meso_rst_sync.sv
`timescale 1ns/1ps
module meso_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/meso_sync_vec.sv
`timescale 1ns/1ps
module meso_sync_vec #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
    end else begin
      pipe_q[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/meso_wr_side.sv
`timescale 1ns/1ps
module meso_wr_side #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_word,
  output logic              live,
  output logic [PW-1:0]     wbin,
  output logic [PW-1:0]     wgray,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] slots_q [DEPTH];
  logic [PW-1:0]     wbin_q, wgray_q, wbin_nx;
  logic              live_q;

  assign wbin_nx = wbin_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= 1'b0;
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      live_q <= 1'b1;
      if (live_q) begin
        wbin_q  <= wbin_nx;
        wgray_q <= PW'(meso_pkg::bin_to_gray(32'(wbin_nx)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (live_q) slots_q[wbin_q[AW-1:0]] <= wr_word;
  end

  assign rd_word = slots_q[rd_addr];
  assign live    = live_q;
  assign wbin    = wbin_q;
  assign wgray   = wgray_q;
endmodule

// File: rtl/meso_rd_side.sv
`timescale 1ns/1ps
module meso_rd_side #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     wgray_async,
  output logic [AW-1:0]     rd_addr,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              err,
  output logic              flowing,
  output logic [PW-1:0]     rbin,
  output logic [PW-1:0]     fill
);
  import meso_pkg::*;

  localparam logic [PW-1:0] HALF_P = PW'(DEPTH / 2);
  localparam logic [PW-1:0] FULL_P = PW'(DEPTH);

  logic [PW-1:0]     wgray_s, wbin_s, rbin_q, fill_w;
  rd_state_e         state_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q, err_q;

  meso_sync_vec #(.W(PW), .STAGES(2)) u_wsync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (wgray_async),
    .q    (wgray_s)
  );

  assign wbin_s = PW'(gray_to_bin(32'(wgray_s)));
  assign fill_w = wbin_s - rbin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_PRIME;
      rbin_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        RD_PRIME: begin
          if (fill_w >= HALF_P) state_q <= RD_FLOW;
        end
        RD_FLOW: begin
          data_q <= rd_word;
          rbin_q <= rbin_q + PW'(1);
          if (fill_w == '0 || fill_w >= FULL_P) err_q <= 1'b1;
        end
        default: state_q <= RD_PRIME;
      endcase
      valid_q <= (state_q == RD_FLOW);
    end
  end

  assign rd_addr   = rbin_q[AW-1:0];
  assign out_data  = data_q;
  assign out_valid = valid_q;
  assign err       = err_q;
  assign flowing   = (state_q == RD_FLOW);
  assign rbin      = rbin_q;
  assign fill      = fill_w;
endmodule

// File: rtl/meso_elastic_buf.sv
`timescale 1ns/1ps
module meso_elastic_buf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              tx_clk,
  input  logic              tx_rst_n,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              rx_clk,
  input  logic              rx_rst_n,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              drift_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic              any_rst_n, w_rst_n, r_rst_n;
  logic [PW-1:0]     wbin, wgray, rbin, fill;
  logic [AW-1:0]     rd_addr;
  logic [DATA_W-1:0] rd_word;
  logic              flowing;

  assign any_rst_n = tx_rst_n & rx_rst_n;

  meso_rst_sync #(.STAGES(2)) u_wrst (
    .clk(tx_clk), .arst_n(any_rst_n), .rst_n(w_rst_n)
  );
  meso_rst_sync #(.STAGES(2)) u_rrst (
    .clk(rx_clk), .arst_n(any_rst_n), .rst_n(r_rst_n)
  );

  meso_wr_side #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_wr (
    .clk    (tx_clk),
    .rst_n  (w_rst_n),
    .wr_word(tx_data),
    .live   (tx_ready),
    .wbin   (wbin),
    .wgray  (wgray),
    .rd_addr(rd_addr),
    .rd_word(rd_word)
  );

  meso_rd_side #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
    .clk        (rx_clk),
    .rst_n      (r_rst_n),
    .wgray_async(wgray),
    .rd_addr    (rd_addr),
    .rd_word    (rd_word),
    .out_data   (rx_data),
    .out_valid  (rx_valid),
    .err        (drift_err),
    .flowing    (flowing),
    .rbin       (rbin),
    .fill       (fill)
  );
endmodule

// File: rtl/meso_eb_checker.sv
`timescale 1ns/1ps
module meso_eb_checker #(
  parameter int DEPTH = 8,
  parameter int PW    = 4
) (
  input logic          tx_clk,
  input logic          rx_clk,
  input logic          w_rst_n,
  input logic          r_rst_n,
  input logic          tx_ready,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] wgray,
  input logic          flowing,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] fill,
  input logic          rx_valid,
  input logic          drift_err
);
  localparam logic [PW-1:0] HALF_P = PW'(DEPTH / 2);

  AST_READY_HOLDS: assert property (@(posedge tx_clk) disable iff (!w_rst_n)
    tx_ready |=> tx_ready); // R2
  AST_WPTR_STEP: assert property (@(posedge tx_clk) disable iff (!w_rst_n)
    $past(tx_ready) |-> wbin == $past(wbin) + PW'(1)); // R2
  AST_GRAY_ONE_BIT: assert property (@(posedge tx_clk) disable iff (!w_rst_n)
    $onehot0(wgray ^ $past(wgray))); // R5
  AST_RPTR_PARKED: assert property (@(posedge rx_clk) disable iff (!r_rst_n)
    !flowing |-> rbin == '0); // R3
  AST_START_AT_HALF: assert property (@(posedge rx_clk) disable iff (!r_rst_n)
    $rose(flowing) |-> $past(fill) >= HALF_P); // R3
  AST_RPTR_STEP: assert property (@(posedge rx_clk) disable iff (!r_rst_n)
    (flowing && $past(flowing)) |-> rbin == $past(rbin) + PW'(1)); // R5
  AST_NO_VALID_PRIMING: assert property (@(posedge rx_clk) disable iff (!r_rst_n)
    !flowing |=> !rx_valid); // R4
  AST_VALID_HOLDS: assert property (@(posedge rx_clk) disable iff (!r_rst_n)
    rx_valid |=> rx_valid); // R4
  AST_ERR_STICKY: assert property (@(posedge rx_clk) disable iff (!r_rst_n)
    drift_err |=> drift_err); // R6
endmodule

bind meso_elastic_buf meso_eb_checker #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .tx_clk   (tx_clk),
  .rx_clk   (rx_clk),
  .w_rst_n  (w_rst_n),
  .r_rst_n  (r_rst_n),
  .tx_ready (tx_ready),
  .wbin     (wbin),
  .wgray    (wgray),
  .flowing  (flowing),
  .rbin     (rbin),
  .fill     (fill),
  .rx_valid (rx_valid),
  .drift_err(drift_err)
);

// File: tb/sim_meso_elastic_buf.sv
`timescale 1ns/1ps
module sim_meso_elastic_buf;
  localparam int DW    = 16;
  localparam int DEPTH = 8;
  localparam int HALF  = DEPTH / 2;
  localparam int PER   = 20;

  logic          tx_clk = 1'b0, rx_clk = 1'b0;
  logic          tx_rst_n = 1'b0, rx_rst_n = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic          tx_ready, rx_valid, drift_err;
  logic [DW-1:0] rx_data;

  bit  wrun = 1'b1, rrun = 1'b1;
  int  rphase = 3;
  int  mode = 0;
  int  word_cnt = 0;
  bit  chk_on = 1'b0;
  bit  seen_valid = 1'b0;
  bit  done = 1'b0;
  int  n_cmp = 0, n_bad = 0;
  realtime t_ready = 0, t_valid = 0;
  logic [DW-1:0] exp_q [$];

  meso_elastic_buf #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .drift_err(drift_err)
  );

  // 50 MHz on both sides; rx edge placed rphase ns into each period
  always begin
    #(PER / 2);
    if (wrun) tx_clk = ~tx_clk;
  end
  always begin
    #(rphase);
    if (rrun) rx_clk = 1'b1;
    #(PER / 2);
    rx_clk = 1'b0;
    #(PER / 2 - rphase);
  end

  function automatic logic [DW-1:0] gen_word(input int m, input int c);
    case (m)
      0:       return DW'(c);
      1:       return DW'((c * 40503) ^ 16'h3c5a);
      default: return (c[0] ? DW'(16'haaaa) : DW'(16'h5555)) ^ DW'(c >> 1);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: new word each tx cycle; push it when the write side will take it
  initial forever begin
    @(negedge tx_clk);
    tx_data = gen_word(mode, word_cnt);
    word_cnt++;
    if (tx_ready) exp_q.push_back(tx_data);
  end

  // monitor: pop and compare every delivered word
  initial forever begin
    @(negedge rx_clk);
    if (chk_on) begin
      if (rx_valid) begin
        seen_valid = 1'b1;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "word delivered with nothing stored", 1, 0);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(rx_data == e, "R5", "delivered word", int'(rx_data), int'(e));
        end
      end else if (seen_valid) begin
        check(1'b0, "R4", "rx_valid dropped after start", 0, 1);
      end
    end
  end

  initial forever begin
    @(posedge tx_ready);
    t_ready = $realtime;
  end
  initial forever begin
    @(posedge rx_valid);
    t_valid = $realtime;
  end

  task automatic wait_start(input string req);
    bit got;
    got = 1'b0;
    for (int i = 0; i < 100 && !got; i++) begin
      @(negedge rx_clk);
      got = rx_valid;
    end
    check(got, req, "rx_valid rose after priming", int'(got), 1);
  endtask

  task automatic check_latency();
    real lat;
    lat = (t_valid - t_ready) / PER;
    check(lat >= HALF && lat <= HALF + 6, "R3", "start latency (periods x10)",
          int'(lat * 10), HALF * 10);
  endtask

  task automatic fresh_run(input int ph, input int m);
    chk_on   = 1'b0;
    tx_rst_n = 1'b0;
    rx_rst_n = 1'b0;
    repeat (4) @(negedge tx_clk);
    rphase = ph;
    mode   = m;
    repeat (3) @(negedge tx_clk);
    exp_q.delete();
    seen_valid = 1'b0;
    chk_on     = 1'b1;
    tx_rst_n   = 1'b1;
    rx_rst_n   = 1'b1;
    wait_start("R3");
    check_latency();
  endtask

  task automatic steady(input int cycles, input string req);
    int maxq;
    maxq = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge tx_clk);
      if (exp_q.size() > maxq) maxq = exp_q.size();
    end
    check(drift_err == 1'b0, req, "drift_err in matched run", int'(drift_err), 0);
    check(maxq <= DEPTH, "R7", "peak undelivered words", maxq, DEPTH);
    check(tx_ready == 1'b1, "R2", "tx_ready held high", int'(tx_ready), 1);
  endtask

  task automatic restart_one(input bit rx_side);
    chk_on = 1'b0;
    if (rx_side) rx_rst_n = 1'b0; else tx_rst_n = 1'b0;
    repeat (4) @(negedge tx_clk);
    check(drift_err == 1'b0, "R8", "drift_err cleared by one-side reset", int'(drift_err), 0);
    check(rx_valid == 1'b0, "R8", "rx_valid low in one-side reset", int'(rx_valid), 0);
    check(tx_ready == 1'b0, "R8", "tx_ready low in one-side reset", int'(tx_ready), 0);
    exp_q.delete();
    seen_valid = 1'b0;
    chk_on = 1'b1;
    rx_rst_n = 1'b1;
    tx_rst_n = 1'b1;
    wait_start("R8");
    check_latency();
    steady(120, "R8");
  endtask

  initial begin
    #(200_000 * PER);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (5) @(negedge tx_clk);
    check(tx_ready == 1'b0, "R1", "tx_ready in reset", int'(tx_ready), 0);
    check(rx_valid == 1'b0, "R1", "rx_valid in reset", int'(rx_valid), 0);
    check(drift_err == 1'b0, "R1", "drift_err in reset", int'(drift_err), 0);

    // R5/R7: three patterns, three phase offsets
    fresh_run(3, 0);
    steady(300, "R7");
    fresh_run(9, 1);
    steady(300, "R7");
    fresh_run(1, 2);
    steady(300, "R7");

    // R6: receive stall overfills
    chk_on = 1'b0;
    @(negedge rx_clk);
    rrun = 1'b0;
    #((DEPTH + 2) * PER);
    rrun = 1'b1;
    repeat (10) @(negedge rx_clk);
    check(drift_err == 1'b1, "R6", "overfill flagged", int'(drift_err), 1);
    repeat (30) @(negedge rx_clk);
    check(drift_err == 1'b1, "R6", "flag sticky after overfill", int'(drift_err), 1);

    // R8: receive-side reset alone restarts everything
    restart_one(1'b1);

    // R6: transmit stall drains
    chk_on = 1'b0;
    @(negedge tx_clk);
    wrun = 1'b0;
    #((HALF + 4) * PER);
    wrun = 1'b1;
    repeat (10) @(negedge rx_clk);
    check(drift_err == 1'b1, "R6", "drain flagged", int'(drift_err), 1);
    repeat (30) @(negedge rx_clk);
    check(drift_err == 1'b1, "R6", "flag sticky after drain", int'(drift_err), 1);

    // R8: transmit-side reset alone restarts everything
    mode = 1;
    restart_one(1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule